// File: doc/BRIEF.md
# Page Entry Permission Checker

This block decides whether a memory access may use a leaf page table entry that has already been found. Each cycle it takes the entry, the page size exponent, the requester's privilege level, the access kind and the virtual address, plus a flag that selects the narrow (32-bit) entry layout. One clock later it reports a result code, the physical address, the granted permissions and the privilege index of the mapping.

The checks follow a fixed order, and the first one that fails sets the result. Presence is checked first, then execute inhibit on fetches, then read inhibit on loads, then privilege, and finally write permission on stores. Privilege works in one of two ways, chosen by a bit in the entry. In the normal way the requester's level may not exceed the entry's level. In the restricted way the two levels must be equal.

The physical address takes the frame number from the entry. Frame bits that lie inside the page offset are treated as software bits and dropped. The page offset bits come from the virtual address.

Top module: `pte_perm_check`

## Requirements
- R1: While `rst` is high at a clock edge, the outputs become result code 1 (invalid), with a zero address, zero permissions and zero privilege index.
- R2: Outputs show the inputs that were present at the previous rising clock edge (one register stage).
- R3: If the valid bit (entry bit 0) is clear, the result is code 1, whatever the other fields and the access kind.
- R4: For a valid entry, a fetch (access 0) with no-execute (bit 62) set gives code 2. Otherwise a load (access 1) with no-read (bit 61) set gives code 3. Both of these outrank the privilege check.
- R5: When the restricted-privilege bit (bit 63) is 0, a requester level numerically greater than the entry level (bits 3:2) gives code 4.
- R6: When the restricted-privilege bit is 1, any requester level that differs from the entry level gives code 4.
- R7: A store (access 2) to an entry whose writable bit (bit 1) is clear gives code 5. This check has the lowest priority.
- R8: On a match (code 0), the physical address is the frame number shifted left by 12, with every bit below PS cleared, ORed with the low PS bits of the virtual address. PS ranges from 12 to PA_W, and the wide frame field is bits [47:12].
- R9: On a match, the permission output {exec, write, read} has read set to 1, write equal to the writable bit and exec equal to the inverse of no-execute. The privilege index equals the entry level.
- R10: When the narrow layout is selected, no-execute, no-read and restricted privilege all count as zero, and the frame number comes from entry bits [31:8].
- R11: For any result other than a match, the address, the permissions and the privilege index are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pte_i | input | 64 | Leaf page table entry |
| page_shift_i | input | 7 | Page size exponent PS (12..PA_W) |
| req_plv_i | input | 2 | Requester privilege level |
| access_i | input | 2 | 0 fetch, 1 load, 2 store |
| vaddr_i | input | 64 | Virtual address |
| narrow_i | input | 1 | Selects the 32-bit entry layout |
| result_o | output | 3 | 0 match, 1 invalid, 2 no-exec, 3 no-read, 4 privilege, 5 dirty |
| paddr_o | output | 48 | Physical address |
| perm_o | output | 3 | Granted permissions {exec, write, read} |
| eff_plv_o | output | 2 | Privilege index of the mapping |

## Verification
The bench builds the block with its default parameters: a 48-bit physical address, the wide frame at bits [47:12] and the narrow frame at bits [31:8]. With these values the full page size range from 12 to 48 can be reached, including a page exponent equal to the address width, where every address bit comes from the virtual address. It also brings within reach the case where the narrow frame field overlaps the low flag area of the wide layout. The fault chain is stepped through by clearing one cause at a time, so every adjacent pair of priorities is exercised.

// File: rtl/pte_chk_pkg.sv
package pte_chk_pkg;

  typedef enum logic [2:0] {
    RES_MATCH   = 3'd0,
    RES_INVALID = 3'd1,
    RES_NOEXEC  = 3'd2,
    RES_NOREAD  = 3'd3,
    RES_PRIV    = 3'd4,
    RES_DIRTY   = 3'd5
  } res_e;

  typedef enum logic [1:0] {
    ACC_FETCH = 2'd0,
    ACC_LOAD  = 2'd1,
    ACC_STORE = 2'd2,
    ACC_RSVD  = 2'd3
  } acc_e;

  typedef struct packed {
    logic       valid;
    logic       writable;
    logic [1:0] plv;
    logic       no_read;
    logic       no_exec;
    logic       excl_plv;
  } pte_flags_t;

endpackage

// File: rtl/pte_field_decode.sv
module pte_field_decode
  import pte_chk_pkg::*;
#(
  parameter int ENTRY_W   = 64,
  parameter int PA_W      = 48,
  parameter int FRAME_SH  = 12,
  parameter int V_BIT     = 0,
  parameter int D_BIT     = 1,
  parameter int PLV_LSB   = 2,
  parameter int NR_BIT    = 61,
  parameter int NX_BIT    = 62,
  parameter int XPLV_BIT  = 63,
  parameter int PPN_LSB   = 12,
  parameter int PPN32_LSB = 8,
  parameter int PPN32_W   = 24
) (
  input  logic [ENTRY_W-1:0] entry_i,
  input  logic               narrow_i,
  output pte_flags_t         flags_o,
  output logic [PA_W-1:0]    frame_o
);
  localparam int PPN_W = PA_W - FRAME_SH;

  logic [PA_W-1:0] frame_wide, frame_narrow;

  assign frame_wide   = PA_W'(entry_i[PPN_LSB +: PPN_W]) << FRAME_SH;
  assign frame_narrow = PA_W'(entry_i[PPN32_LSB +: PPN32_W]) << FRAME_SH;

  always_comb begin
    flags_o.valid    = entry_i[V_BIT];
    flags_o.writable = entry_i[D_BIT];
    flags_o.plv      = entry_i[PLV_LSB +: 2];
    flags_o.no_read  = narrow_i ? 1'b0 : entry_i[NR_BIT];
    flags_o.no_exec  = narrow_i ? 1'b0 : entry_i[NX_BIT];
    flags_o.excl_plv = narrow_i ? 1'b0 : entry_i[XPLV_BIT];
    frame_o          = narrow_i ? frame_narrow : frame_wide;
  end
endmodule

// File: rtl/pte_fault_rank.sv
module pte_fault_rank
  import pte_chk_pkg::*;
(
  input  pte_flags_t flags_i,
  input  logic [1:0] req_plv_i,
  input  logic [1:0] access_i,
  output res_e       res_o
);
  logic plv_bad;

  always_comb begin
    if (flags_i.excl_plv) plv_bad = (req_plv_i != flags_i.plv);
    else                  plv_bad = (req_plv_i > flags_i.plv);
  end

  always_comb begin
    if (!flags_i.valid)
      res_o = RES_INVALID;
    else if (access_i == ACC_FETCH && flags_i.no_exec)
      res_o = RES_NOEXEC;
    else if (access_i == ACC_LOAD && flags_i.no_read)
      res_o = RES_NOREAD;
    else if (plv_bad)
      res_o = RES_PRIV;
    else if (access_i == ACC_STORE && !flags_i.writable)
      res_o = RES_DIRTY;
    else
      res_o = RES_MATCH;
  end
endmodule

// File: rtl/pte_addr_compose.sv
module pte_addr_compose #(
  parameter int PA_W = 48,
  parameter int VA_W = 64,
  parameter int PS_W = 7
) (
  input  logic [PA_W-1:0] frame_i,
  input  logic [VA_W-1:0] vaddr_i,
  input  logic [PS_W-1:0] page_shift_i,
  output logic [PA_W-1:0] paddr_o
);
  logic [PA_W-1:0] offs_mask;

  for (genvar i = 0; i < PA_W; i++) begin : g_mask
    assign offs_mask[i] = (page_shift_i > PS_W'(i));
  end

  assign paddr_o = (frame_i & ~offs_mask) | (vaddr_i[PA_W-1:0] & offs_mask);
endmodule

// File: rtl/pte_perm_check.sv
module pte_perm_check
  import pte_chk_pkg::*;
#(
  parameter int ENTRY_W   = 64,
  parameter int VA_W      = 64,
  parameter int PA_W      = 48,
  parameter int PS_W      = 7,
  parameter int FRAME_SH  = 12,
  parameter int V_BIT     = 0,
  parameter int D_BIT     = 1,
  parameter int PLV_LSB   = 2,
  parameter int NR_BIT    = 61,
  parameter int NX_BIT    = 62,
  parameter int XPLV_BIT  = 63,
  parameter int PPN_LSB   = 12,
  parameter int PPN32_LSB = 8,
  parameter int PPN32_W   = 24
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [ENTRY_W-1:0] pte_i,
  input  logic [PS_W-1:0]    page_shift_i,
  input  logic [1:0]         req_plv_i,
  input  logic [1:0]         access_i,
  input  logic [VA_W-1:0]    vaddr_i,
  input  logic               narrow_i,
  output logic [2:0]         result_o,
  output logic [PA_W-1:0]    paddr_o,
  output logic [2:0]         perm_o,
  output logic [1:0]         eff_plv_o
);
  pte_flags_t      flags;
  logic [PA_W-1:0] frame, paddr_c;
  res_e            res_c;

  pte_field_decode #(
    .ENTRY_W(ENTRY_W), .PA_W(PA_W), .FRAME_SH(FRAME_SH),
    .V_BIT(V_BIT), .D_BIT(D_BIT), .PLV_LSB(PLV_LSB),
    .NR_BIT(NR_BIT), .NX_BIT(NX_BIT), .XPLV_BIT(XPLV_BIT),
    .PPN_LSB(PPN_LSB), .PPN32_LSB(PPN32_LSB), .PPN32_W(PPN32_W)
  ) u_decode (
    .entry_i (pte_i),
    .narrow_i(narrow_i),
    .flags_o (flags),
    .frame_o (frame)
  );

  pte_fault_rank u_rank (
    .flags_i  (flags),
    .req_plv_i(req_plv_i),
    .access_i (access_i),
    .res_o    (res_c)
  );

  pte_addr_compose #(.PA_W(PA_W), .VA_W(VA_W), .PS_W(PS_W)) u_addr (
    .frame_i     (frame),
    .vaddr_i     (vaddr_i),
    .page_shift_i(page_shift_i),
    .paddr_o     (paddr_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      result_o  <= RES_INVALID;
      paddr_o   <= '0;
      perm_o    <= '0;
      eff_plv_o <= '0;
    end else begin
      result_o <= res_c;
      if (res_c == RES_MATCH) begin
        paddr_o   <= paddr_c;
        perm_o    <= {~flags.no_exec, flags.writable, 1'b1};
        eff_plv_o <= flags.plv;
      end else begin
        paddr_o   <= '0;
        perm_o    <= '0;
        eff_plv_o <= '0;
      end
    end
  end
endmodule

// File: rtl/pte_perm_check_chk.sv
module pte_perm_check_chk #(
  parameter int ENTRY_W  = 64,
  parameter int VA_W     = 64,
  parameter int PA_W     = 48,
  parameter int PS_W     = 7,
  parameter int V_BIT    = 0,
  parameter int NX_BIT   = 62
) (
  input logic               clk,
  input logic               rst,
  input logic [ENTRY_W-1:0] pte_i,
  input logic [PS_W-1:0]    page_shift_i,
  input logic [1:0]         access_i,
  input logic               narrow_i,
  input logic [2:0]         result_o,
  input logic [PA_W-1:0]    paddr_o,
  input logic [2:0]         perm_o,
  input logic [1:0]         eff_plv_o
);
  logic primed;
  always_ff @(posedge clk) begin
    if (rst) primed <= 1'b0;
    else     primed <= 1'b1;
  end

  // R3
  invalid_first_chk: assert property (@(posedge clk) disable iff (rst)
    primed && !$past(pte_i[V_BIT]) |-> result_o == 3'd1);

  // R11
  nomatch_zero_chk: assert property (@(posedge clk) disable iff (rst)
    primed && result_o != 3'd0 |-> paddr_o == '0 && perm_o == 3'b000 && eff_plv_o == 2'd0);

  // R9
  read_granted_chk: assert property (@(posedge clk) disable iff (rst)
    primed && result_o == 3'd0 |-> perm_o[0]);

  // R7
  store_write_chk: assert property (@(posedge clk) disable iff (rst)
    primed && result_o == 3'd0 && $past(access_i) == 2'd2 |-> perm_o[1]);

  // R10
  narrow_noexec_chk: assert property (@(posedge clk) disable iff (rst)
    primed && $past(narrow_i) |-> result_o != 3'd2 && result_o != 3'd3);

  // R4
  noexec_fetch_chk: assert property (@(posedge clk) disable iff (rst)
    primed && $past(pte_i[V_BIT]) && $past(pte_i[NX_BIT]) && !$past(narrow_i)
      && $past(access_i) == 2'd0 |-> result_o == 3'd2);

  // R8
  shift_range_chk: assert property (@(posedge clk) disable iff (rst)
    page_shift_i >= PS_W'(12) && page_shift_i <= PS_W'(PA_W));
endmodule

bind pte_perm_check pte_perm_check_chk #(
  .ENTRY_W(ENTRY_W), .VA_W(VA_W), .PA_W(PA_W), .PS_W(PS_W),
  .V_BIT(V_BIT), .NX_BIT(NX_BIT)
) u_chk (
  .clk(clk), .rst(rst), .pte_i(pte_i), .page_shift_i(page_shift_i),
  .access_i(access_i), .narrow_i(narrow_i), .result_o(result_o),
  .paddr_o(paddr_o), .perm_o(perm_o), .eff_plv_o(eff_plv_o)
);

// File: tb/tb_pte_perm_check.sv
`timescale 1ns/1ps
module tb_pte_perm_check;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [63:0] pte = '0;
  logic [6:0]  ps  = 7'd12;
  logic [1:0]  plv = '0;
  logic [1:0]  acc = '0;
  logic [63:0] va  = '0;
  logic        nar = 1'b0;
  logic [2:0]  res;
  logic [47:0] pa;
  logic [2:0]  perm;
  logic [1:0]  eplv;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  pte_perm_check dut (
    .clk(clk), .rst(rst), .pte_i(pte), .page_shift_i(ps), .req_plv_i(plv),
    .access_i(acc), .vaddr_i(va), .narrow_i(nar), .result_o(res),
    .paddr_o(pa), .perm_o(perm), .eff_plv_o(eplv)
  );

  function automatic logic [63:0] mk(input logic [35:0] ppn, input bit v, input bit d,
                                     input logic [1:0] lv, input bit nr, input bit nx,
                                     input bit xp);
    logic [63:0] e;
    e = {16'b0, ppn, 12'b0};
    e[0] = v; e[1] = d; e[3:2] = lv; e[61] = nr; e[62] = nx; e[63] = xp;
    return e;
  endfunction

  function automatic logic [47:0] exp_pa(input logic [47:0] frame, input logic [6:0] s,
                                         input logic [63:0] v);
    logic [63:0] m, r;
    m = (64'd1 << s) - 64'd1;
    r = ({16'b0, frame} & ~m) | (v & m);
    return r[47:0];
  endfunction

  task automatic check(input string tag, input logic [2:0] er, input logic [47:0] ea,
                       input logic [2:0] ep, input logic [1:0] el);
    tests++;
    if (res !== er || pa !== ea || perm !== ep || eplv !== el) begin
      fails++;
      $display("FAIL %s: got res=%0d pa=%h perm=%b plv=%0d exp res=%0d pa=%h perm=%b plv=%0d",
               tag, res, pa, perm, eplv, er, ea, ep, el);
    end
  endtask

  task automatic apply(input logic [63:0] e, input logic [6:0] s, input logic [1:0] lv,
                       input logic [1:0] a, input logic [63:0] v, input bit n);
    @(negedge clk);
    pte = e; ps = s; plv = lv; acc = a; va = v; nar = n;
    @(posedge clk);
    #1;
  endtask

  task automatic t_reset();
    apply(mk(36'h1, 1, 1, 3, 0, 0, 0), 12, 0, 1, 64'h123, 0);
    check("R1 reset state", 3'd1, 48'h0, 3'b000, 2'd0);
    @(negedge clk); rst = 1'b0;
  endtask

  task automatic t_priority();
    logic [63:0] e;
    e = mk(36'h5, 0, 0, 0, 1, 1, 0);
    apply(e, 12, 3, 0, 64'h0, 0);
    check("R3 invalid before all", 3'd1, 48'h0, 3'b000, 2'd0);
    apply(e, 12, 3, 2, 64'h0, 0);
    check("R3 invalid on store", 3'd1, 48'h0, 3'b000, 2'd0);
    e[0] = 1'b1;
    apply(e, 12, 3, 0, 64'h0, 0);
    check("R4 no-exec on fetch", 3'd2, 48'h0, 3'b000, 2'd0);
    apply(e, 12, 3, 1, 64'h0, 0);
    check("R4 no-read on load", 3'd3, 48'h0, 3'b000, 2'd0);
    apply(e, 12, 3, 2, 64'h0, 0);
    check("R5 privilege before dirty", 3'd4, 48'h0, 3'b000, 2'd0);
    e[3:2] = 2'd3;
    apply(e, 12, 3, 2, 64'h0, 0);
    check("R7 dirty fault on store", 3'd5, 48'h0, 3'b000, 2'd0);
    e[62] = 1'b0;
    apply(e, 12, 3, 0, 64'h0000_0000_0000_0abc, 0);
    check("R9 fetch ignores no-read", 3'd0, 48'h5abc, 3'b101, 2'd3);
  endtask

  task automatic t_privilege();
    logic [63:0] e;
    e = mk(36'h7, 1, 1, 1, 0, 0, 0);
    apply(e, 12, 0, 1, 64'h0, 0);
    check("R5 lower level allowed", 3'd0, 48'h7000, 3'b111, 2'd1);
    apply(e, 12, 2, 1, 64'h0, 0);
    check("R5 higher level refused", 3'd4, 48'h0, 3'b000, 2'd0);
    e[63] = 1'b1;
    apply(e, 12, 0, 1, 64'h0, 0);
    check("R6 restricted lower refused", 3'd4, 48'h0, 3'b000, 2'd0);
    apply(e, 12, 1, 2, 64'h0, 0);
    check("R6 restricted exact allowed", 3'd0, 48'h7000, 3'b111, 2'd1);
    apply(e, 12, 3, 0, 64'h0, 0);
    check("R6 restricted higher refused", 3'd4, 48'h0, 3'b000, 2'd0);
  endtask

  task automatic t_address();
    logic [35:0] ppn;
    logic [63:0] v;
    logic [6:0]  sizes [4];
    ppn = 36'h9_8765_4321;
    v   = 64'hA5A5_FEDC_BA98_7654;
    sizes[0] = 12; sizes[1] = 21; sizes[2] = 30; sizes[3] = 48;
    foreach (sizes[k]) begin
      apply(mk(ppn, 1, 0, 2, 0, 1, 0), sizes[k], 1, 1, v, 0);
      check($sformatf("R8 address ps=%0d", sizes[k]), 3'd0,
            exp_pa({ppn, 12'b0}, sizes[k], v), 3'b001, 2'd2);
    end
  endtask

  task automatic t_narrow();
    logic [63:0] e;
    e = 64'hE000_0000_0000_0000 | (64'hABCDE1 << 8) | 64'h9;
    apply(e, 12, 1, 0, 64'h0000_0000_0000_0FED, 1);
    check("R10 narrow ignores flags", 3'd0, 48'hAB_CDE1_FED, 3'b101, 2'd2);
    apply(e, 12, 3, 1, 64'h0, 1);
    check("R10 narrow ceiling check", 3'd4, 48'h0, 3'b000, 2'd0);
    apply(e, 12, 1, 2, 64'h0, 1);
    check("R10 narrow store dirty", 3'd5, 48'h0, 3'b000, 2'd0);
  endtask

  task automatic t_latency();
    apply(mk(36'h3, 1, 1, 0, 0, 0, 0), 12, 0, 1, 64'h11, 0);
    @(negedge clk);
    pte = mk(36'h3, 0, 1, 0, 0, 0, 0);
    #0.5;
    check("R2 output held until edge", 3'd0, 48'h3011, 3'b111, 2'd0);
    @(posedge clk); #1;
    check("R2 output after edge", 3'd1, 48'h0, 3'b000, 2'd0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    t_reset();
    t_priority();
    t_privilege();
    t_address();
    t_narrow();
    t_latency();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL R2 watchdog expired: got hang exp completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule